// File: doc/BRIEF.md
# Averaged Fault Protection Supervisor

This block supervises a two-stage power converter: a boost front end that charges a bulk capacitor, and a current-regulated second stage that drives the LED load. It does not act on a single comparator glitch. It keeps a running average of each over-stress indication and trips only when that average says the stress has lasted too long. Each average is a saturating up/down counter that moves on a periodic sample tick.

Two fault classes are handled, and each has its own response. A boost overvoltage disables the boost stage. The second stage keeps running with its dim command forced to full scale, so it drains the bulk capacitor quickly. When a separate recovery comparator reports that the boost output has fallen back to the lower threshold, the boost is re-armed. A clamp overpower event occurs when the clamp switch has been on for more than 49% of the time on average. It shuts down both stages, holds the clamp off, and stays latched until reset. A line-range input, captured only during reset, selects between the low-line comparator thresholds (249 V trip, 195 V recovery) and the high-line thresholds (448 V trip, 368 V recovery). The block drives that selection out to the analog comparators.

Top module: `fault_supervisor`

## Requirements
- R1: After reset, boost_en_o=1, stage2_en_o=1, dim_full_o=0 and clamp_inhibit_o=0.
- R2: hi_thr_sel_o takes the value of hi_line_i sampled while rst_n is low (1 = high-line thresholds). Changes of hi_line_i after reset has been released have no effect.
- R3: With ov_flag_i held high from a cleared state, boost_en_o is still 1 after OV_TICKS-1 ticks and is 0 after OV_TICKS ticks. OV_TICKS = 1.6 ms / tick period, which is 16 at the default 100 us tick.
- R4: The overvoltage average leaks by one step on each tick with ov_flag_i low. A 50% alternating flag never trips. A 75% pattern (three ticks high, one low) trips.
- R5: While an overvoltage event is active and no clamp fault is present, stage2_en_o stays 1 and dim_full_o is 1.
- R6: During an overvoltage event, recov_flag_i=1 re-enables the boost and removes the dim override. Outside an event, recov_flag_i has no effect on the overvoltage average.
- R7: On recovery the overvoltage average is cleared, so a new trip needs a full OV_TICKS ticks of flag.
- R8: With clamp_on_i held high from a cleared state, the clamp fault fires after exactly CL_TICKS ticks and not before. CL_TICKS = 13.8 ms / tick period, which is 138 at the default tick.
- R9: The clamp average rises by 51 on a tick with the clamp on and falls by 49 on a tick with it off, so its balance point is 49% duty. A 49% duty pattern never trips, and a 60% duty pattern trips.
- R10: A clamp fault drives boost_en_o=0, stage2_en_o=0 and clamp_inhibit_o=1. These values hold until reset, whatever the other inputs do.
- R11: While a clamp fault is latched, an overvoltage event or a recovery flag neither re-enables a stage nor raises dim_full_o.
- R12: The averages move only on cycles with tick_i=1. Fault flags held for any number of cycles without a tick cause no trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | Single-cycle sample strobe that advances the averages |
| hi_line_i | input | 1 | Line range select, captured during reset (1 = high line) |
| ov_flag_i | input | 1 | Boost overvoltage comparator output |
| recov_flag_i | input | 1 | Boost recovered comparator output (at or below recovery threshold) |
| clamp_on_i | input | 1 | Clamp switch on state |
| boost_en_o | output | 1 | Boost stage enable |
| stage2_en_o | output | 1 | Second stage enable |
| dim_full_o | output | 1 | Forces the second-stage dim command to full scale |
| clamp_inhibit_o | output | 1 | Holds the clamp switch off |
| hi_thr_sel_o | output | 1 | Selects high-line comparator thresholds |

## Verification
The assertions take for granted that every input is synchronous to clk and changes only between edges. They also assume that recov_flag_i describes the boost voltage truthfully, so that the boost is re-armed on the cycle after recovery unless a clamp fault lands on the same edge. The tick input is assumed to be a strobe of one cycle; nothing in the properties depends on its spacing. The bench drives every input on the falling edge and sends ticks as pulses of one cycle two clocks apart. It raises recovery only where a real drop of the boost voltage would, or where it tests that the flag is ignored.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

    // Registered supervisor state
    typedef struct packed {
        logic ov_act;   // overvoltage event in progress
        logic cop_lat;  // clamp overpower fault latched
        logic hi_line;  // captured line range
    } sup_state_t;

    // Integer ceiling-free tick count for a time limit
    function automatic int unsigned ticks_for(input int unsigned limit_ns,
                                              input int unsigned tick_ns);
        return limit_ns / tick_ns;
    endfunction

endpackage

// File: rtl/fsup_integ.sv
// Saturating up/down running-average integrator, advanced on a sample tick.
module fsup_integ #(
    parameter int unsigned UP_STEP = 1,
    parameter int unsigned DN_STEP = 1,
    parameter int unsigned TRIP_AT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic hit_i,
    input  logic clr_i,
    output logic trip_o
);
    localparam int unsigned CW = $clog2(TRIP_AT + UP_STEP + 1);
    localparam logic [CW-1:0] TOP  = CW'(TRIP_AT);
    localparam logic [CW-1:0] UPW  = CW'(UP_STEP);
    localparam logic [CW-1:0] DNW  = CW'(DN_STEP);

    logic [CW-1:0] acc_d, acc_q;
    logic [CW-1:0] sum;

    always_comb begin
        sum   = acc_q + UPW;
        acc_d = acc_q;
        if (clr_i) begin
            acc_d = '0;
        end else if (tick_i) begin
            if (hit_i) begin
                acc_d = (sum >= TOP) ? TOP : sum;
            end else begin
                acc_d = (acc_q < DNW) ? '0 : acc_q - DNW;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign trip_o = (acc_q >= TOP);

endmodule

// File: rtl/fsup_resp.sv
// Fault response controller: event state and stage gating.
module fsup_resp
    import fsup_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hi_line_i,
    input  logic ov_trip_i,
    input  logic cl_trip_i,
    input  logic recov_i,
    output logic ov_clr_o,
    output logic boost_en_o,
    output logic stage2_en_o,
    output logic dim_full_o,
    output logic clamp_inh_o,
    output logic hi_sel_o
);
    sup_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cl_trip_i) begin
            st_d.cop_lat = 1'b1;
        end
        if (st_q.ov_act) begin
            if (recov_i) st_d.ov_act = 1'b0;
        end else if (ov_trip_i) begin
            st_d.ov_act = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ov_act  <= 1'b0;
            st_q.cop_lat <= 1'b0;
            st_q.hi_line <= hi_line_i;
        end else begin
            st_q <= st_d;
        end
    end

    assign ov_clr_o    = st_q.ov_act & recov_i;
    assign boost_en_o  = ~st_q.cop_lat & ~st_q.ov_act;
    assign stage2_en_o = ~st_q.cop_lat;
    assign dim_full_o  = ~st_q.cop_lat & st_q.ov_act;
    assign clamp_inh_o = st_q.cop_lat;
    assign hi_sel_o    = st_q.hi_line;

endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
    import fsup_pkg::*;
#(
    parameter int unsigned TICK_NS     = 100_000,
    parameter int unsigned OV_LIMIT_NS = 1_600_000,
    parameter int unsigned CL_LIMIT_NS = 13_800_000,
    parameter int unsigned CL_DUTY_PCT = 49
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic hi_line_i,
    input  logic ov_flag_i,
    input  logic recov_flag_i,
    input  logic clamp_on_i,
    output logic boost_en_o,
    output logic stage2_en_o,
    output logic dim_full_o,
    output logic clamp_inhibit_o,
    output logic hi_thr_sel_o
);
    localparam int unsigned OV_TICKS = ticks_for(OV_LIMIT_NS, TICK_NS);
    localparam int unsigned CL_TICKS = ticks_for(CL_LIMIT_NS, TICK_NS);
    localparam int unsigned CL_UP    = 100 - CL_DUTY_PCT;
    localparam int unsigned CL_DN    = CL_DUTY_PCT;
    localparam int unsigned CL_TRIP  = CL_TICKS * CL_UP;

    logic ov_trip, cl_trip, ov_clr;

    fsup_integ #(
        .UP_STEP (1),
        .DN_STEP (1),
        .TRIP_AT (OV_TICKS)
    ) u_ov_avg (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .hit_i  (ov_flag_i),
        .clr_i  (ov_clr),
        .trip_o (ov_trip)
    );

    fsup_integ #(
        .UP_STEP (CL_UP),
        .DN_STEP (CL_DN),
        .TRIP_AT (CL_TRIP)
    ) u_cl_avg (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .hit_i  (clamp_on_i),
        .clr_i  (1'b0),
        .trip_o (cl_trip)
    );

    fsup_resp u_resp (
        .clk         (clk),
        .rst_n       (rst_n),
        .hi_line_i   (hi_line_i),
        .ov_trip_i   (ov_trip),
        .cl_trip_i   (cl_trip),
        .recov_i     (recov_flag_i),
        .ov_clr_o    (ov_clr),
        .boost_en_o  (boost_en_o),
        .stage2_en_o (stage2_en_o),
        .dim_full_o  (dim_full_o),
        .clamp_inh_o (clamp_inhibit_o),
        .hi_sel_o    (hi_thr_sel_o)
    );

endmodule

// File: rtl/fsup_checker.sv
module fsup_checker (
    input logic clk,
    input logic rst_n,
    input logic recov_flag_i,
    input logic boost_en_o,
    input logic stage2_en_o,
    input logic dim_full_o,
    input logic clamp_inhibit_o,
    input logic hi_thr_sel_o
);
    a_r10_fault_latched: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_inhibit_o |=> clamp_inhibit_o);

    a_r10_stages_off: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_inhibit_o |-> (!boost_en_o && !stage2_en_o));

    a_r11_no_override: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_inhibit_o |-> !dim_full_o);

    a_r5_drain_full: assert property (@(posedge clk) disable iff (!rst_n)
        (!boost_en_o && !clamp_inhibit_o) |-> (stage2_en_o && dim_full_o));

    a_r6_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (!boost_en_o && !clamp_inhibit_o && recov_flag_i) |=> (boost_en_o || clamp_inhibit_o));

    a_r2_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(hi_thr_sel_o));

endmodule

bind fault_supervisor fsup_checker u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .recov_flag_i    (recov_flag_i),
    .boost_en_o      (boost_en_o),
    .stage2_en_o     (stage2_en_o),
    .dim_full_o      (dim_full_o),
    .clamp_inhibit_o (clamp_inhibit_o),
    .hi_thr_sel_o    (hi_thr_sel_o)
);

// File: tb/sim_fault_supervisor.sv
module sim_fault_supervisor;
    localparam int OV_N = 16;
    localparam int CL_N = 138;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, hi_line = 1'b0, ov = 1'b0, rc = 1'b0, cl = 1'b0;
    logic boost_en, stage2_en, dim_full, clamp_inh, hi_sel;
    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    fault_supervisor u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .hi_line_i(hi_line),
        .ov_flag_i(ov), .recov_flag_i(rc), .clamp_on_i(cl),
        .boost_en_o(boost_en), .stage2_en_o(stage2_en), .dim_full_o(dim_full),
        .clamp_inhibit_o(clamp_inh), .hi_thr_sel_o(hi_sel)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic tk(input logic ov_v, input logic cl_v);
        @(negedge clk); ov = ov_v; cl = cl_v; tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk); rst_n = 1'b0; hi_line = mode; ov = 0; rc = 0; cl = 0; tick = 0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic t_reset_state;
        do_reset(1'b0);
        chk("R1 boost_en", boost_en, 1'b1);
        chk("R1 stage2_en", stage2_en, 1'b1);
        chk("R1 dim_full", dim_full, 1'b0);
        chk("R1 clamp_inh", clamp_inh, 1'b0);
    endtask

    task automatic t_mode;
        do_reset(1'b1);
        chk("R2 high line captured", hi_sel, 1'b1);
        hi_line = 1'b0; idle(5);
        chk("R2 change after reset ignored", hi_sel, 1'b1);
        do_reset(1'b0);
        chk("R2 low line captured", hi_sel, 1'b0);
    endtask

    task automatic t_ov_exact;
        do_reset(1'b0);
        for (int i = 0; i < OV_N - 1; i++) tk(1, 0);
        idle(2);
        chk("R3 no trip before limit", boost_en, 1'b1);
        tk(1, 0); idle(2);
        chk("R3 trip at limit", boost_en, 1'b0);
        chk("R5 stage2 kept on", stage2_en, 1'b1);
        chk("R5 dim forced full", dim_full, 1'b1);
    endtask

    task automatic t_ov_leak;
        do_reset(1'b0);
        for (int i = 0; i < 200; i++) tk(i % 2 == 0, 0);
        idle(2);
        chk("R4 50pct never trips", boost_en, 1'b1);
        do_reset(1'b0);
        for (int i = 0; i < 40; i++) tk(i % 4 != 3, 0);
        idle(2);
        chk("R4 75pct trips", boost_en, 1'b0);
    endtask

    task automatic t_recovery;
        do_reset(1'b0);
        for (int i = 0; i < 10; i++) tk(1, 0);
        @(negedge clk); rc = 1'b1; @(negedge clk); rc = 1'b0;
        for (int i = 0; i < OV_N - 10; i++) tk(1, 0);
        idle(2);
        chk("R6 recov ignored outside event", boost_en, 1'b0);
        ov = 1'b0;
        @(negedge clk); rc = 1'b1; @(negedge clk); rc = 1'b0;
        idle(1);
        chk("R6 boost re-enabled", boost_en, 1'b1);
        chk("R6 override removed", dim_full, 1'b0);
        for (int i = 0; i < OV_N - 1; i++) tk(1, 0);
        idle(2);
        chk("R7 average cleared on recovery", boost_en, 1'b1);
        tk(1, 0); idle(2);
        chk("R7 full interval trips again", boost_en, 1'b0);
    endtask

    task automatic t_clamp_exact;
        do_reset(1'b0);
        for (int i = 0; i < CL_N - 1; i++) tk(0, 1);
        idle(2);
        chk("R8 no clamp fault before limit", clamp_inh, 1'b0);
        tk(0, 1); idle(2);
        chk("R8 clamp fault at limit", clamp_inh, 1'b1);
        chk("R10 boost off", boost_en, 1'b0);
        chk("R10 stage2 off", stage2_en, 1'b0);
        cl = 1'b0;
        for (int i = 0; i < 50; i++) tk(0, 0);
        @(negedge clk); rc = 1'b1; @(negedge clk); rc = 1'b0;
        idle(2);
        chk("R10 latched after clamp off", clamp_inh, 1'b1);
        chk("R10 stage2 stays off", stage2_en, 1'b0);
        for (int i = 0; i < OV_N + 2; i++) tk(1, 0);
        idle(2);
        chk("R11 no override under fault", dim_full, 1'b0);
        @(negedge clk); rc = 1'b1; @(negedge clk); rc = 1'b0;
        idle(2);
        chk("R11 recovery does not restart boost", boost_en, 1'b0);
        chk("R11 recovery does not restart stage2", stage2_en, 1'b0);
    endtask

    task automatic t_clamp_duty;
        do_reset(1'b0);
        for (int i = 0; i < 1000; i++) tk(0, (i % 100) < 49);
        idle(2);
        chk("R9 49pct duty never trips", clamp_inh, 1'b0);
        do_reset(1'b0);
        for (int i = 0; i < 1000; i++) tk(0, (i % 5) < 3);
        idle(2);
        chk("R9 60pct duty trips", clamp_inh, 1'b1);
    endtask

    task automatic t_no_tick;
        do_reset(1'b0);
        @(negedge clk); ov = 1'b1; cl = 1'b1;
        idle(400);
        chk("R12 no tick no overvoltage trip", boost_en, 1'b1);
        chk("R12 no tick no clamp trip", clamp_inh, 1'b0);
        ov = 1'b0; cl = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_mode();
        t_ov_exact();
        t_ov_leak();
        t_recovery();
        t_clamp_exact();
        t_clamp_duty();
        t_no_tick();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule